// File: doc/BRIEF.md
# Pipelined Feistel Round Slice with Private Lookup Tables

This block performs one round of a 64-bit, sixteen-round-style Feistel cipher that uses key-dependent byte substitution. A block enters as two 32-bit halves together with the 32-bit subkey for this round. The left half is XORed with the subkey. Its four bytes select one word from each of four private 256-entry lookup tables. The four words are combined by addition and XOR into a mixing value, which is XORed into the right half. The two halves are then exchanged. The exchange can be suppressed for the closing round of a chain.

The slice keeps its own copy of the four tables, loaded through a single write port. It holds a register between the table read and the mixing logic, and another at its output. Several slices can therefore be cascaded into a fully unrolled cipher that accepts a new block on every clock, with two cycles of latency per slice. A valid flag moves along with each block. Subkey and table generation happen outside the slice.

Top module: `feistel_round_slice`

## Requirements
- R1: While `rst_n` is low at a rising edge, the following edge leaves `out_vld` at 0 and `out_left` and `out_right` at all zeros.
- R2: `out_vld` equals the `in_vld` presented two rising edges earlier, and a new block is accepted on every cycle.
- R3: The keyed left half is K = `in_left` XOR `subkey`. Its bits 31:24 index table 0, bits 23:16 index table 1, bits 15:8 index table 2 and bits 7:0 index table 3.
- R4: The mixing value is M = ((T0[a] + T1[b]) XOR T2[c]) + T3[d], with both additions taken modulo 2^32.
- R5: With `swap_off` = 0, the result two cycles later is `out_left` = M XOR `in_right` and `out_right` = K.
- R6: With `swap_off` = 1, the result two cycles later is `out_left` = K and `out_right` = M XOR `in_right`.
- R7: When `tbl_we` = 1, `tbl_wdata` is written to table number `tbl_sel` (0 to 3) at index `tbl_addr`. Lookups issued on any later cycle see the new word.
- R8: A lookup issued in the same cycle as a write to the entry it reads returns the word held before that write.
- R9: Blocks presented on consecutive cycles, with or without idle cycles between them, each produce their own correct result in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Incoming block is valid |
| in_left | input | 32 | Left half of incoming block |
| in_right | input | 32 | Right half of incoming block |
| subkey | input | 32 | Round subkey |
| swap_off | input | 1 | 1 suppresses the half exchange |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 2 | Table number to write |
| tbl_addr | input | 8 | Table index to write |
| tbl_wdata | input | 32 | Word to write |
| out_vld | output | 1 | Outgoing block is valid |
| out_left | output | 32 | Left half of result |
| out_right | output | 32 | Right half of result |

## Verification
A table write and a block lookup can land in the same cycle and target the same table entry. The bench provokes this by choosing the block's keyed byte to equal the write index on the written table. The result must be built from the word held before the write (R8). The bench then re-issues the same block on the next cycle and expects the newly written word (R7). The expected values come from the bench's own table copy. It evaluates each block against that copy before applying the same cycle's write, and the design's output two cycles later is compared with that value.

// File: rtl/fsl_pkg.sv
// Package: shared widths and stage record for the Feistel round slice.
// Assumes a 32-bit half-block split into four byte indices.
package fsl_pkg;
    localparam int unsigned FSL_WORD_W  = 32;
    localparam int unsigned FSL_IDX_W   = 8;
    localparam int unsigned FSL_NUM_TBL = 4;
    localparam int unsigned FSL_SEL_W   = $clog2(FSL_NUM_TBL);

    // Record held in the mid-round register
    typedef struct packed {
        logic                  vld;
        logic                  keep;
        logic [FSL_WORD_W-1:0] kl;
        logic [FSL_WORD_W-1:0] xr;
    } fsl_mid_t;
endpackage

// File: rtl/fsl_table_mem.sv
// Module: one lookup table with a synchronous read port and a write port.
// Assumes one read and one write per cycle. A read that meets a write to
// the same index returns the old word (read before write). Contents are
// not reset and must be loaded before use.
module fsl_table_mem #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Registered read and write; nonblocking update gives old data on a clash
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/fsl_mix.sv
// Module: combinational mixing function over four looked-up words.
// Assumes w[0] to w[3] are the words read from tables 0 to 3.
module fsl_mix #(
    parameter int unsigned WORD_W = 32
) (
    input  logic [3:0][WORD_W-1:0] w,
    output logic [WORD_W-1:0]      mix
);
    logic [WORD_W-1:0] sum01;
    logic [WORD_W-1:0] x2;

    // Add, XOR, add; additions wrap at the word width
    always_comb begin
        sum01 = w[0] + w[1];
        x2    = sum01 ^ w[2];
        mix   = x2 + w[3];
    end
endmodule

// File: rtl/feistel_round_slice.sv
// Module: one Feistel round as a two-stage pipeline with private tables.
// Stage 1 keys the left half and launches the four table reads while
// delaying the keyed left and the right half. Stage 2 mixes the read words,
// folds them into the right half and exchanges halves unless swap_off.
// Assumes the tables are loaded through the write port before use.
module feistel_round_slice
    import fsl_pkg::*;
#(
    parameter int unsigned IDX_W = FSL_IDX_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_vld,
    input  logic [FSL_WORD_W-1:0] in_left,
    input  logic [FSL_WORD_W-1:0] in_right,
    input  logic [FSL_WORD_W-1:0] subkey,
    input  logic                  swap_off,
    input  logic                  tbl_we,
    input  logic [FSL_SEL_W-1:0]  tbl_sel,
    input  logic [IDX_W-1:0]      tbl_addr,
    input  logic [FSL_WORD_W-1:0] tbl_wdata,
    output logic                  out_vld,
    output logic [FSL_WORD_W-1:0] out_left,
    output logic [FSL_WORD_W-1:0] out_right
);
    localparam int unsigned WORD_W = FSL_WORD_W;

    logic [WORD_W-1:0]                 keyed;
    logic [FSL_NUM_TBL-1:0][WORD_W-1:0] rd_word;
    logic [WORD_W-1:0]                 mix;
    logic [WORD_W-1:0]                 new_r;
    fsl_mid_t                          mid_q;

    // Key the left half with the round subkey
    always_comb keyed = in_left ^ subkey;

    // One table per byte lane; lane 0 takes the most significant byte
    for (genvar g = 0; g < FSL_NUM_TBL; g++) begin : g_tbl
        fsl_table_mem #(
            .DATA_W(WORD_W),
            .ADDR_W(IDX_W)
        ) u_tbl (
            .clk  (clk),
            .we   (tbl_we && (tbl_sel == FSL_SEL_W'(g))),
            .waddr(tbl_addr),
            .wdata(tbl_wdata),
            .raddr(keyed[WORD_W-1-g*IDX_W -: IDX_W]),
            .rdata(rd_word[g])
        );
    end

    // Mid-round register: aligns keyed left and right half with table data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_q <= '0;
        end else begin
            mid_q.vld  <= in_vld;
            mid_q.keep <= swap_off;
            mid_q.kl   <= keyed;
            mid_q.xr   <= in_right;
        end
    end

    fsl_mix #(.WORD_W(WORD_W)) u_mix (
        .w  (rd_word),
        .mix(mix)
    );

    // Fold mixing value into the right half
    always_comb new_r = mix ^ mid_q.xr;

    // Output register with optional half exchange
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld   <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            out_vld <= mid_q.vld;
            if (mid_q.keep) begin
                out_left  <= mid_q.kl;
                out_right <= new_r;
            end else begin
                out_left  <= new_r;
                out_right <= mid_q.kl;
            end
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_vld && out_left == '0 && out_right == '0));

    // R2
    vld_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |-> ##2 out_vld);

    // R2
    bubble_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |-> ##2 !out_vld);

    // R5
    swapped_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !swap_off) |-> ##2 (out_right == $past(in_left ^ subkey, 2)));

    // R6
    kept_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && swap_off) |-> ##2 (out_left == $past(in_left ^ subkey, 2)));
endmodule

// File: tb/test_feistel_round_slice.sv
module test_feistel_round_slice;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [31:0] in_left = '0, in_right = '0, subkey = '0;
    logic        swap_off = 1'b0;
    logic        tbl_we = 1'b0;
    logic [1:0]  tbl_sel = '0;
    logic [7:0]  tbl_addr = '0;
    logic [31:0] tbl_wdata = '0;
    logic        out_vld;
    logic [31:0] out_left, out_right;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] ref_tbl [4][256];

    // bench-side two-deep expectation pipe
    logic        p1_v = 1'b0, p2_v = 1'b0;
    logic [31:0] p1_l, p1_r, p2_l, p2_r;
    string       p1_tag = "", p2_tag = "";

    always #4 clk = ~clk;

    feistel_round_slice i_feistel_round_slice (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_left(in_left),
        .in_right(in_right), .subkey(subkey), .swap_off(swap_off),
        .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata), .out_vld(out_vld), .out_left(out_left),
        .out_right(out_right)
    );

    function automatic logic [31:0] ref_mix(input logic [31:0] k);
        logic [31:0] s;
        s = ref_tbl[0][k[31:24]] + ref_tbl[1][k[23:16]];
        s = s ^ ref_tbl[2][k[15:8]];
        return s + ref_tbl[3][k[7:0]];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: check the output due now, then drive a block and/or write
    task automatic cyc(input string tag, input logic v, input logic [31:0] l,
                       input logic [31:0] r, input logic [31:0] k, input logic so,
                       input logic we, input logic [1:0] sel, input logic [7:0] a,
                       input logic [31:0] wd);
        logic [31:0] kl, nr;
        @(negedge clk);
        check({p2_tag, " R2 valid"}, {31'd0, out_vld}, {31'd0, p2_v});
        if (p2_v) begin
            check({p2_tag, " left"}, out_left, p2_l);
            check({p2_tag, " right"}, out_right, p2_r);
        end
        p2_v = p1_v; p2_l = p1_l; p2_r = p1_r; p2_tag = p1_tag;
        kl = l ^ k;                 // R3
        nr = ref_mix(kl) ^ r;       // R4, using tables before this cycle's write (R8)
        p1_v = v; p1_tag = tag;
        p1_l = so ? kl : nr;
        p1_r = so ? nr : kl;
        if (we) ref_tbl[sel][a] = wd;
        in_vld = v; in_left = l; in_right = r; subkey = k; swap_off = so;
        tbl_we = we; tbl_sel = sel; tbl_addr = a; tbl_wdata = wd;
    endtask

    task automatic idle(input string tag);
        cyc(tag, 1'b0, '0, '0, '0, 1'b0, 1'b0, 2'd0, 8'd0, '0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; in_vld = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 out_vld", {31'd0, out_vld}, 32'd0);
        check("R1 out_left", out_left, 32'd0);
        check("R1 out_right", out_right, 32'd0);
        in_vld = 1'b0; rst_n = 1'b1;
        p1_v = 1'b0; p2_v = 1'b0; p1_tag = "R1"; p2_tag = "R1";
    endtask

    task automatic t_load();
        for (int t = 0; t < 4; t++) begin
            for (int i = 0; i < 256; i++) begin
                logic [31:0] w;
                w = (32'(i) * 32'h9E3779B1) ^ (32'(t) << 28) ^ (32'(i) << 5) ^ 32'h5A17C3E9 * 32'(t + 1);
                cyc("R7 load", 1'b0, '0, '0, '0, 1'b0, 1'b1, 2'(t), 8'(i), w);
            end
        end
        idle("R7"); idle("R7");
    endtask

    task automatic t_single();
        cyc("R5 single", 1'b1, 32'h01234567, 32'h89ABCDEF, 32'h0F1E2D3C, 1'b0, 1'b0, 2'd0, 8'd0, '0);
        idle("R5"); idle("R5");
        cyc("R6 single", 1'b1, 32'hDEADBEEF, 32'h00000000, 32'hFFFFFFFF, 1'b1, 1'b0, 2'd0, 8'd0, '0);
        idle("R6"); idle("R6");
        cyc("R3 zero key", 1'b1, 32'h00FF7F80, 32'h12345678, 32'h00000000, 1'b0, 1'b0, 2'd0, 8'd0, '0);
        idle("R3"); idle("R3");
        cyc("R4 all ones", 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b0, 2'd0, 8'd0, '0);
        idle("R4"); idle("R4");
    endtask

    task automatic t_stream();
        logic [31:0] s = 32'hC0FFEE11;
        for (int i = 0; i < 60; i++) begin
            logic v;
            s = s * 32'd1664525 + 32'd1013904223;
            v = (i % 7) != 3;
            cyc("R9 stream", v, s ^ 32'h3C3C3C3C, {s[15:0], s[31:16]}, s * 32'd3, s[9], 1'b0, 2'd0, 8'd0, '0);
        end
        idle("R9"); idle("R9"); idle("R9");
    endtask

    task automatic t_clash();
        // keyed = 32'h5A_11_22_33: table 0 index 0x5A
        cyc("R8 clash", 1'b1, 32'h5A112233, 32'hA5A5A5A5, 32'h0, 1'b0, 1'b1, 2'd0, 8'h5A, 32'h13579BDF);
        cyc("R7 after write", 1'b1, 32'h5A112233, 32'hA5A5A5A5, 32'h0, 1'b0, 1'b0, 2'd0, 8'd0, '0);
        cyc("R8 clash t3", 1'b1, 32'h00000077, 32'h0, 32'h0, 1'b1, 1'b1, 2'd3, 8'h77, 32'hFEDCBA98);
        cyc("R7 after write t3", 1'b1, 32'h00000077, 32'h0, 32'h0, 1'b1, 1'b0, 2'd0, 8'd0, '0);
        idle("R8"); idle("R8"); idle("R8");
    endtask

    initial begin
        t_reset();
        t_load();
        t_single();
        t_stream();
        t_clash();
        cyc("R9 pre-reset", 1'b1, 32'h1, 32'h2, 32'h3, 1'b0, 1'b0, 2'd0, 8'd0, '0);
        t_reset();
        idle("R1"); idle("R1");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule